// File: doc/BRIEF.md
# Multi-mode transfer count controller

This block keeps the transfer counts for a small DMA-style engine. Software loads two 16-bit count registers through a plain write port and sets per-source enable bits. The engine reports each finished unit of data with a one-cycle strobe and names the source it served. The controller decrements the right counter, announces block boundaries and the end of the whole transfer, and clears the serving source's enable bit when its work is over.

Count register A works in one of two shapes. In normal mode it is one 16-bit down-counter. In repeat and block modes its high byte is a reload value and its low byte an 8-bit down-counter that refills itself from the high byte. Count register B counts blocks in block mode. A programmed zero always stands for the full range of the counter (65536 or 256). The block carries no data stream, so every pin is plain control or status with no valid/ready handshake and no back-pressure: each strobe is consumed in the cycle it is presented.

Top module: `xfer_count_ctrl`

## Requirements
- R1: After reset, `cnt_a`, `cnt_b` and `en_bits` are all zero and `xfer_end` and `blk_done` are low.
- R2: A write with `wr_en` high loads `wr_data` into register A when `wr_sel` is 0 and into register B when `wr_sel` is 1; the new value is visible on the next cycle.
- R3: In normal mode (`mode` = 2'b00) an accepted strobe lowers A by one; when A is 1, `xfer_end` is high in that cycle and A becomes 0. A loaded as 0 counts 65536 transfers: a strobe takes it to 16'hFFFF without `xfer_end`.
- R4: In repeat mode (`mode` = 2'b01) an accepted strobe lowers A bits 7:0 by one and leaves bits 15:8 alone; when bits 7:0 are 1 they are refilled from bits 15:8, a low byte of 0 counts 256, and `xfer_end` never goes high.
- R5: In block mode (`mode` = 2'b10) the low byte of A behaves as in R4; on each refill `blk_done` is high in that cycle and B drops by one, and `xfer_end` is high exactly when that refill finds B at 1. `blk_done` is never high outside block mode.
- R6: A strobe is ignored (no counter change, no pulse, no enable change) when the enable bit selected by `src_sel` is 0 or when `mode` is 2'b11.
- R7: `en_set[i]` high sets enable bit i on the next cycle, and wins over a clear of the same bit in that cycle.
- R8: When `xfer_end` is high, the enable bit selected by `src_sel` is 0 on the next cycle.
- R9: With `disel` high, any accepted strobe clears the selected enable bit; with `disel` low it stays set while the count is not exhausted.
- R10: A register write in the same cycle as an accepted strobe wins for that register's value, while `xfer_end`, `blk_done` and the enable clearing still follow the count held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Count register write strobe |
| wr_sel | input | 1 | Write target: 0 register A, 1 register B |
| wr_data | input | CNT_W | Value to write |
| mode | input | 2 | 00 normal, 01 repeat, 10 block, 11 no transfers |
| disel | input | 1 | Clear the enable bit after every transfer |
| en_set | input | NUM_SRC | Per-source enable set pulses |
| src_sel | input | SRC_W | Source that the current strobe belongs to |
| unit_xfer | input | 1 | One-cycle strobe: one data unit moved |
| cnt_a | output | CNT_W | Count register A |
| cnt_b | output | CNT_W | Count register B |
| en_bits | output | NUM_SRC | Per-source enable bits |
| xfer_end | output | 1 | Whole transfer ended in this cycle |
| blk_done | output | 1 | Block boundary in this cycle (block mode) |

## Verification
Normal mode is run from a small count down to its end, and from a loaded zero, so the terminal value 1 is told apart from the full-range zero. Repeat mode runs across several refills and from a zero low byte, which tells a refill from a wrap to 8'hFF and shows that no end is ever raised. Block mode with a one-unit block and a two-block count separates the block pulse from the end pulse. Strobes on disabled sources, in the reserved mode, with the per-transfer clear option, with a colliding write and with a set colliding with a clear each show whether a priority or a gate is wired the wrong way.

// File: rtl/xcc_pkg.sv
package xcc_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_NONE   = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/xcc_cnt_a.sv
module xcc_cnt_a #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dec,
  input  logic             split,
  output logic [CNT_W-1:0] cnt,
  output logic             term,
  output logic             wrap
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] hi_part, lo_part;
  logic              lo_last, whole_last;

  assign hi_part    = cnt_q[CNT_W-1:HALF_W];
  assign lo_part    = cnt_q[HALF_W-1:0];
  assign lo_last    = (lo_part == HALF_W'(1));
  assign whole_last = (cnt_q == CNT_W'(1));

  assign term = dec && !split && whole_last;
  assign wrap = dec && split && lo_last;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (dec) begin
      if (!split)
        cnt_d = cnt_q - CNT_W'(1);
      else if (lo_last)
        cnt_d = {hi_part, hi_part};
      else
        cnt_d = {hi_part, lo_part - HALF_W'(1)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/xcc_cnt_b.sv
module xcc_cnt_b #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             term
);
  logic [CNT_W-1:0] cnt_q;

  assign term = dec && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (dec)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/xcc_en_bank.sv
module xcc_en_bank #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_i,
  input  logic [SRC_W-1:0]   clr_sel,
  output logic [NUM_SRC-1:0] en_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic hit;
    assign hit = clr_i && (clr_sel == SRC_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q[i] <= 1'b0;
      else if (set_i[i]) en_q[i] <= 1'b1;
      else if (hit)      en_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl
  import xcc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 16,
  parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [1:0]         mode,
  input  logic               disel,
  input  logic [NUM_SRC-1:0] en_set,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic               unit_xfer,
  output logic [CNT_W-1:0]   cnt_a,
  output logic [CNT_W-1:0]   cnt_b,
  output logic [NUM_SRC-1:0] en_bits,
  output logic               xfer_end,
  output logic               blk_done
);
  xfer_mode_e md;
  logic       act, split, wr_a, wr_b;
  logic       term_a, term_b, wrap_a, dec_b, clr;

  assign md    = xfer_mode_e'(mode);
  assign act   = unit_xfer && en_bits[src_sel] && (md != XM_NONE);
  assign split = (md != XM_NORMAL);
  assign wr_a  = wr_en && !wr_sel;
  assign wr_b  = wr_en && wr_sel;
  assign dec_b = wrap_a && (md == XM_BLOCK);

  xcc_cnt_a #(.CNT_W(CNT_W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .wr_data(wr_data),
    .dec(act), .split(split), .cnt(cnt_a), .term(term_a), .wrap(wrap_a)
  );

  xcc_cnt_b #(.CNT_W(CNT_W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wr_data(wr_data),
    .dec(dec_b), .cnt(cnt_b), .term(term_b)
  );

  assign xfer_end = term_a || term_b;
  assign blk_done = dec_b;
  assign clr      = act && (disel || xfer_end);

  xcc_en_bank #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_en (
    .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(clr),
    .clr_sel(src_sel), .en_q(en_bits)
  );
endmodule

// File: rtl/xcc_checker.sv
module xcc_checker #(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 16,
  parameter int SRC_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         mode,
  input logic               disel,
  input logic [NUM_SRC-1:0] en_set,
  input logic [SRC_W-1:0]   src_sel,
  input logic               act,
  input logic [CNT_W-1:0]   cnt_a,
  input logic [NUM_SRC-1:0] en_bits,
  input logic               xfer_end,
  input logic               blk_done
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !wr_en) |=> $stable(cnt_a));

  p_norm_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode == 2'b00 && !wr_en) |=> (cnt_a == $past(cnt_a) - CNT_W'(1)));

  p_rep_no_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> !xfer_end);

  p_blk_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (mode == 2'b10));

  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set) |=> ((en_bits & $past(en_set)) == $past(en_set)));

  p_end_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !en_set[src_sel]) |=> !en_bits[$past(src_sel)]);

  p_disel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && disel && !en_set[src_sel]) |=> !en_bits[$past(src_sel)]);
endmodule

bind xfer_count_ctrl xcc_checker #(
  .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode(mode), .disel(disel),
  .en_set(en_set), .src_sel(src_sel), .act(act), .cnt_a(cnt_a),
  .en_bits(en_bits), .xfer_end(xfer_end), .blk_done(blk_done)
);

// File: tb/tb_xfer_count_ctrl.sv
module tb_xfer_count_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, disel = 1'b0, unit_xfer = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mode = 2'b00;
  logic [3:0]  en_set = '0;
  logic [1:0]  src_sel = '0;
  logic [15:0] cnt_a, cnt_b;
  logic [3:0]  en_bits;
  logic        xfer_end, blk_done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  xfer_count_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode(mode), .disel(disel), .en_set(en_set), .src_sel(src_sel),
    .unit_xfer(unit_xfer), .cnt_a(cnt_a), .cnt_b(cnt_b), .en_bits(en_bits),
    .xfer_end(xfer_end), .blk_done(blk_done)
  );

  typedef struct {
    string       req;
    logic        e;
    logic        b;
    logic [15:0] a;
    logic [15:0] cb;
    logic [3:0]  en;
  } exp_t;

  exp_t q[$];
  logic [15:0] m_a = '0, m_b = '0;
  logic [3:0]  m_en = '0;

  task automatic step(input string req, input logic wr, input logic ws,
                      input logic [15:0] wd, input logic [1:0] md,
                      input logic [3:0] st, input logic [1:0] sel,
                      input logic u, input logic dis);
    exp_t it;
    logic ok;
    logic [15:0] na, nb;
    logic [3:0] ne;
    @(negedge clk);
    wr_en = wr; wr_sel = ws; wr_data = wd; mode = md; en_set = st;
    src_sel = sel; unit_xfer = u; disel = dis;
    ok = u && m_en[sel] && (md != 2'b11);
    it.req = req; it.e = 1'b0; it.b = 1'b0;
    na = m_a; nb = m_b;
    if (ok) begin
      if (md == 2'b00) begin
        na = m_a - 16'd1;
        it.e = (m_a == 16'd1);
      end else if (m_a[7:0] == 8'd1) begin
        na[7:0] = m_a[15:8];
        if (md == 2'b10) begin
          it.b = 1'b1;
          nb = m_b - 16'd1;
          it.e = (m_b == 16'd1);
        end
      end else begin
        na[7:0] = m_a[7:0] - 8'd1;
      end
    end
    if (wr && !ws) na = wd;
    if (wr && ws)  nb = wd;
    ne = m_en;
    if (ok && (dis || it.e)) ne[sel] = 1'b0;
    ne = ne | st;
    m_a = na; m_b = nb; m_en = ne;
    it.a = na; it.cb = nb; it.en = ne;
    q.push_back(it);
  endtask

  task automatic idle(input string req, input logic [1:0] md);
    step(req, 0, 0, 16'h0, md, 4'h0, 2'd0, 0, 0);
  endtask

  // monitor: pulses before the edge, registers after it
  initial begin
    exp_t it;
    logic ge, gb;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        ge = xfer_end; gb = blk_done;
        @(posedge clk);
        #1;
        checks++;
        if (ge !== it.e || gb !== it.b || cnt_a !== it.a || cnt_b !== it.cb || en_bits !== it.en) begin
          failures++;
          $display("FAIL %s: end=%b blk=%b a=%h b=%h en=%b expected end=%b blk=%b a=%h b=%h en=%b",
                   it.req, ge, gb, cnt_a, cnt_b, en_bits, it.e, it.b, it.a, it.cb, it.en);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    checks++;
    if (cnt_a !== 16'h0 || cnt_b !== 16'h0 || en_bits !== 4'h0 || xfer_end !== 1'b0 || blk_done !== 1'b0) begin
      failures++;
      $display("FAIL R1: a=%h b=%h en=%b end=%b blk=%b expected all zero",
               cnt_a, cnt_b, en_bits, xfer_end, blk_done);
    end

    // R2: writes to both registers, R7: enable set
    step("R2 write A", 1, 0, 16'h0003, 2'b00, 4'b0011, 2'd0, 0, 0);
    step("R2 write B", 1, 1, 16'h0002, 2'b00, 4'b0000, 2'd0, 0, 0);
    // R3: count down to end, R8: end clears enable
    for (int k = 0; k < 3; k++) step("R3 R8 normal count", 0, 0, 0, 2'b00, 0, 2'd0, 1, 0);
    // R6: strobe on cleared source ignored
    step("R6 disabled source", 0, 0, 0, 2'b00, 0, 2'd0, 1, 0);
    idle("R6 after disabled", 2'b00);
    // R3: zero means full range
    step("R3 load zero", 1, 0, 16'h0000, 2'b00, 4'b0001, 2'd0, 0, 0);
    step("R3 full range", 0, 0, 0, 2'b00, 0, 2'd0, 1, 0);
    // R4: repeat mode refills, never ends
    step("R4 load", 1, 0, 16'h0202, 2'b01, 0, 2'd0, 0, 0);
    for (int k = 0; k < 5; k++) step("R4 repeat", 0, 0, 0, 2'b01, 0, 2'd0, 1, 0);
    step("R4 low zero", 1, 0, 16'h0300, 2'b01, 0, 2'd0, 0, 0);
    step("R4 low zero wrap", 0, 0, 0, 2'b01, 0, 2'd0, 1, 0);
    // R5: block mode, one-unit blocks, two blocks
    step("R5 load A", 1, 0, 16'h0101, 2'b10, 0, 2'd1, 0, 0);
    step("R5 load B", 1, 1, 16'h0002, 2'b10, 0, 2'd1, 0, 0);
    step("R5 block 1", 0, 0, 0, 2'b10, 0, 2'd1, 1, 0);
    step("R5 block 2 end", 0, 0, 0, 2'b10, 0, 2'd1, 1, 0);
    idle("R5 after end", 2'b10);
    // R5: two-unit blocks, blk pulse only on refill
    step("R5 reload", 1, 0, 16'h0202, 2'b10, 4'b0100, 2'd2, 0, 0);
    step("R5 reload B", 1, 1, 16'h0003, 2'b10, 0, 2'd2, 0, 0);
    for (int k = 0; k < 4; k++) step("R5 two-unit blocks", 0, 0, 0, 2'b10, 0, 2'd2, 1, 0);
    // R6: reserved mode ignores strobes
    step("R6 reserved mode", 0, 0, 0, 2'b11, 0, 2'd2, 1, 0);
    idle("R6 reserved after", 2'b11);
    // R9: per-transfer clear option
    step("R9 load", 1, 0, 16'h0010, 2'b00, 4'b1000, 2'd3, 0, 0);
    step("R9 disel low holds", 0, 0, 0, 2'b00, 0, 2'd3, 1, 0);
    step("R9 disel high clears", 0, 0, 0, 2'b00, 0, 2'd3, 1, 1);
    // R10: write collides with strobe
    step("R10 set", 1, 0, 16'h0005, 2'b00, 4'b0001, 2'd0, 0, 0);
    step("R10 write wins", 1, 0, 16'h0020, 2'b00, 0, 2'd0, 1, 0);
    step("R10 load one", 1, 0, 16'h0001, 2'b00, 0, 2'd0, 0, 0);
    step("R10 end from old count", 1, 0, 16'h0040, 2'b00, 0, 2'd0, 1, 0);
    // R7: set wins over clear
    step("R7 arm", 1, 0, 16'h0001, 2'b00, 4'b0001, 2'd0, 0, 0);
    step("R7 set beats clear", 0, 0, 0, 2'b00, 4'b0001, 2'd0, 1, 0);
    idle("R7 idle", 2'b00);
    idle("drain", 2'b00);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule